// File: doc/BRIEF.md
# Reload Timer with Square-Wave Output

A 16-bit up-counter with a small register port. The counter starts from a value that software loads and counts up. When it overflows it loads a 16-bit reload register, or returns to zero, and keeps counting.

In clock-out mode the count rate is half the system clock, and each overflow toggles `clk_o`. The result is a square wave with 50% duty cycle whose period is 4·(65536 − reload) system clocks. The same overflow pulses can also serve as receive and transmit baud ticks for a serial port. Both of these uses suppress the sticky overflow flag.

In the general-purpose modes the count rate is the full system clock or one twelfth of it. A falling edge on the synchronised external pin either captures the count into the reload register or forces a reload of the count. In both cases it sets a sticky external flag.

Top module: `t2_clkout_timer`

## Requirements
- R1: Register map on `addr_i`: 0 is the count, 1 is the reload value and 2 is control. Control bits: 0 run, 1 capture select, 2 external enable, 3 receive-baud select, 4 transmit-baud select, 5 clock-out enable, 6 fast clock, 7 up/down enable, 8 overflow flag, 9 external flag. After reset, all registers, `clk_o` and `irq_o` are 0.
- R2: When the count is 0xFFFF and a count tick arrives, the count loads the reload register. This holds when capture select is 0 or a baud select is 1.
- R3: Clock-out is active when clock-out enable is 1 and capture select is 0. While it is active the count ticks every 2nd cycle and `clk_o` toggles on each overflow, so `clk_o` changes level every 2·(65536 − reload) cycles.
- R4: The overflow flag is never set while clock-out is active.
- R5: When neither clock-out nor a baud select is active, the count ticks every cycle if fast clock is 1, and every 12th cycle if fast clock is 0.
- R6: When a baud select is 1, the count ticks every 2nd cycle. `rx_baud_o` and `tx_baud_o` pulse with each overflow, each only when its own select bit is 1, and the overflow flag is not set.
- R7: In other modes an overflow sets the overflow flag. Both flags are sticky. Writing 0 to a flag bit clears it; writing 1 leaves it unchanged.
- R8: With external enable at 1, a falling edge on `ext_i` sets the external flag. It also copies the count into the reload register when capture select is 1, or loads the count from the reload register when capture select is 0. With external enable at 0 the edge changes nothing.
- R9: `irq_o` is the overflow flag OR the external flag, except that the external flag does not drive `irq_o` while up/down enable is 1.
- R10: The count holds while run is 0. A write to the count loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register |
| ext_i | input | 1 | External capture/reload pin (asynchronous) |
| clk_o | output | 1 | Square-wave clock output |
| ovf_o | output | 1 | One-cycle overflow pulse |
| rx_baud_o | output | 1 | Receive baud tick |
| tx_baud_o | output | 1 | Transmit baud tick |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures the spacing between `clk_o` edges and between overflow pulses, at the 0xFFFF reload boundary and at a long period. A prescaler that did not halve the rate, or a reload that was off by one, would shift every interval. The bench reads the overflow flag back after runs in clock-out and baud modes, where a missing suppression would leave it set. It also drives external edges with the timer stopped. A design that swapped capture and reload, or ignored the enable, would leave the wrong value in the count or reload register. The up/down case checks that the external flag alone does not raise `irq_o`.

// File: rtl/t2_timer_pkg.sv
package t2_timer_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CTRL   = 2'd2
  } reg_addr_e;

  // control byte, bit 0 at the bottom
  typedef struct packed {
    logic updown_en;
    logic fast_clk;
    logic clkout_en;
    logic tx_sel;
    logic rx_sel;
    logic ext_en;
    logic cap_sel;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned OVF_BIT   = 8;
  localparam int unsigned EXT_BIT   = 9;
endpackage

// File: rtl/t2_prescale.sv
module t2_prescale #(
  parameter int unsigned SLOW_DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic div2_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  always_comb begin
    if (div2_i)      lim = PW'(1);
    else if (fast_i) lim = '0;
    else             lim = PW'(SLOW_DIV - 1);
  end

  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R3/R6: half-rate ticks never come back to back
  a_r3_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div2_i) |=> !tick_o);
endmodule

// File: rtl/t2_edge_sync.sv
module t2_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/t2_clkout_timer.sv
module t2_clkout_timer
  import t2_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SLOW_DIV = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             ext_i,
  output logic             clk_o,
  output logic             ovf_o,
  output logic             rx_baud_o,
  output logic             tx_baud_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic             ovf_flag_q, ext_flag_q, clk_q;
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic             tick, ext_fall;
  logic             clkout_act, baud_act, reload_mode;
  logic             ovf_evt, ext_evt;
  logic             wr_cnt, wr_rld, wr_ctrl;

  assign clkout_act  = ctrl_q.clkout_en & ~ctrl_q.cap_sel;
  assign baud_act    = ctrl_q.rx_sel | ctrl_q.tx_sel;
  assign reload_mode = ~ctrl_q.cap_sel | baud_act;

  assign wr_cnt  = wr_en_i && (addr_i == REG_COUNT);
  assign wr_rld  = wr_en_i && (addr_i == REG_RELOAD);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);

  t2_prescale #(.SLOW_DIV(SLOW_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .div2_i (clkout_act | baud_act),
    .fast_i (ctrl_q.fast_clk),
    .tick_o (tick)
  );

  t2_edge_sync u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_i),
    .fall_o (ext_fall)
  );

  assign ovf_evt = tick && (cnt_q == '1);
  assign ext_evt = ext_fall && ctrl_q.ext_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata_i;
    end else if (ext_evt && !ctrl_q.cap_sel) begin
      cnt_q <= rld_q;
    end else if (ovf_evt) begin
      cnt_q <= reload_mode ? rld_q : '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rld_q <= '0;
    else if (wr_rld)                      rld_q <= wdata_i;
    else if (ext_evt && ctrl_q.cap_sel)   rld_q <= cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      ovf_flag_q <= 1'b0;
      ext_flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      // hardware set wins over a same-cycle clear
      if (ovf_evt && !clkout_act && !baud_act) ovf_flag_q <= 1'b1;
      else if (wr_ctrl)                        ovf_flag_q <= ovf_flag_q & wdata_i[OVF_BIT];
      if (ext_evt)                             ext_flag_q <= 1'b1;
      else if (wr_ctrl)                        ext_flag_q <= ext_flag_q & wdata_i[EXT_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     clk_q <= 1'b0;
    else if (ovf_evt && clkout_act)  clk_q <= ~clk_q;
  end

  always_comb begin
    unique case (addr_i)
      REG_COUNT:  rdata_o = cnt_q;
      REG_RELOAD: rdata_o = rld_q;
      REG_CTRL:   rdata_o = CNT_W'({ext_flag_q, ovf_flag_q, ctrl_q});
      default:    rdata_o = '0;
    endcase
  end

  assign clk_o     = clk_q;
  assign ovf_o     = ovf_evt;
  assign rx_baud_o = ovf_evt & ctrl_q.rx_sel;
  assign tx_baud_o = ovf_evt & ctrl_q.tx_sel;
  assign irq_o     = ovf_flag_q | (ext_flag_q & ~ctrl_q.updown_en);

  a_r4_no_flag_suppressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_q) |-> $past(!clkout_act && !baud_act));

  a_r3_toggle_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_o) |-> $past(ovf_o && clkout_act));

  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && reload_mode && !wr_cnt && !ext_evt) |=> (cnt_q == $past(rld_q)));

  a_r8_ext_flag_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_flag_q) |-> $past(ctrl_q.ext_en));
endmodule

// File: tb/t2_clkout_timer_test.sv
module t2_clkout_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext = 1'b1;
  logic        clk_out, ovf, rx_b, tx_b, irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int exp_q[$];
  bit mon_on = 1'b0;
  bit mon_ovf = 1'b0;
  int skip = 0;
  int last_ev = 0;
  logic clk_prev = 1'b0;
  int rx_cnt = 0, tx_cnt = 0;
  string mon_tag = "";

  always #4 clk = ~clk;

  t2_clkout_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_i(ext), .clk_o(clk_out), .ovf_o(ovf),
    .rx_baud_o(rx_b), .tx_baud_o(tx_b), .irq_o(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected event spacing and compares
  always @(negedge clk) begin
    bit ev;
    cyc++;
    if (rx_b) rx_cnt++;
    if (tx_b) tx_cnt++;
    ev = mon_ovf ? ovf : (clk_out !== clk_prev);
    clk_prev = clk_out;
    if (mon_on && ev) begin
      if (skip > 0) skip--;
      else if (exp_q.size() > 0) check(mon_tag, cyc - last_ev, exp_q.pop_front());
      last_ev = cyc;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // driver: pushes expected spacings, waits for the monitor to drain them
  task automatic expect_spacing(input string tag, input bit on_ovf, input int n, input int sp);
    int guard = 0;
    mon_on = 1'b0;
    exp_q.delete();
    for (int i = 0; i < n; i++) exp_q.push_back(sp);
    mon_tag = tag; mon_ovf = on_ovf; skip = 1;
    @(negedge clk);
    mon_on = 1'b1;
    while (exp_q.size() > 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    mon_on = 1'b0;
    check({tag, " spacing drained"}, exp_q.size(), 0);
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext = 1'b0;
    repeat (6) @(negedge clk);
    ext = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic start(input logic [15:0] rv, input logic [15:0] c);
    wr(2'd2, 16'h0000);
    wr(2'd1, rv);
    wr(2'd0, rv);
    wr(2'd2, c);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, d); check("R1 count reset", d, 0);
    rd(2'd1, d); check("R1 reload reset", d, 0);
    rd(2'd2, d); check("R1 ctrl reset", d, 0);
    check("R1 clk_o reset", clk_out, 0);
    check("R1 irq reset", irq, 0);

    // R3 clock-out, reload 0xFFF0: 16 ticks x 2 cycles per level
    start(16'hFFF0, 16'h0021);
    expect_spacing("R3 clkout FFF0", 1'b0, 4, 32);
    rd(2'd2, d); check("R4 no ovf flag in clkout", d & 16'h0100, 0);
    check("R4 no irq in clkout", irq, 0);

    // R1/R3 fastest output, reload 0xFFFF
    start(16'hFFFF, 16'h0021);
    expect_spacing("R1 clkout FFFF half rate", 1'b0, 4, 2);

    // R2/R5 auto-reload, fast clock
    start(16'hFFF8, 16'h0041);
    expect_spacing("R2 reload fast FFF8", 1'b1, 3, 8);
    rd(2'd2, d); check("R7 ovf flag set", d & 16'h0100, 16'h0100);
    check("R9 irq from ovf", irq, 1);

    // R5 slow clock, 1/12
    start(16'hFFFE, 16'h0001);
    expect_spacing("R5 slow FFFE", 1'b1, 2, 24);

    // R7 flag clear and write-one no effect
    wr(2'd2, 16'h0000);
    rd(2'd2, d); check("R7 flag cleared by 0", d, 0);
    wr(2'd2, 16'h0300);
    rd(2'd2, d); check("R7 write 1 no set", d & 16'h0300, 0);

    // R6 receive baud
    rx_cnt = 0; tx_cnt = 0;
    start(16'hFFFC, 16'h0009);
    expect_spacing("R6 baud FFFC", 1'b1, 3, 8);
    wr(2'd2, 16'h0000);
    check("R6 rx ticks seen", (rx_cnt > 0) ? 1 : 0, 1);
    check("R6 no tx ticks", tx_cnt, 0);
    rd(2'd2, d); check("R6 ovf flag suppressed", d & 16'h0100, 0);

    // R10 stopped count holds
    wr(2'd0, 16'h5555);
    repeat (30) @(negedge clk);
    rd(2'd0, d); check("R10 stopped count holds", d, 16'h5555);

    // R8 capture
    wr(2'd2, 16'h0006);
    wr(2'd0, 16'h1234);
    ext_pulse();
    rd(2'd1, d); check("R8 capture into reload", d, 16'h1234);
    rd(2'd2, d); check("R8 ext flag set", d & 16'h0200, 16'h0200);
    check("R9 irq from ext", irq, 1);

    // R9 up/down masks ext irq
    wr(2'd2, 16'h0086);
    ext_pulse();
    rd(2'd2, d); check("R9 ext flag set updown", d & 16'h0200, 16'h0200);
    check("R9 no irq in updown", irq, 0);

    // R8 reload on edge
    wr(2'd2, 16'h0004);
    wr(2'd1, 16'hABCD);
    wr(2'd0, 16'h0001);
    ext_pulse();
    rd(2'd0, d); check("R8 edge reload", d, 16'hABCD);

    // R8 disabled edge ignored
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0002);
    ext_pulse();
    rd(2'd0, d); check("R8 disabled edge count", d, 16'h0002);
    rd(2'd2, d); check("R8 disabled edge flag", d & 16'h0200, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule